// File: doc/BRIEF.md
# Comparator-Capture Interval Timer

This block is a 16-bit up-counter that measures time between rising edges of an external comparator output. The count advances once per enable pulse. The pulse comes from one of three sources: every system clock cycle, one system cycle in twelve, or one in eight rising edges of a slow external clock. The counter itself always runs on the system clock. When input capture is armed and the counter is used as one 16-bit value, each rising comparator edge copies the running count into the reload register and raises the high flag. Software subtracts two successive captures to get the comparator period in timer ticks.

Outside capture mode, the same reload register serves as the auto-reload value. In 16-bit mode it is loaded on overflow. In split mode the counter becomes two independent 8-bit counters, and each half reloads from its own byte. A byte-wide register port gives access to control, flags, count and reload. The interrupt request is the enable bit ANDed with the flags. The block has no streaming data path, so every pin is a plain level or strobe.

Top module: `tmr_cap_top`

Register map (byte data, 3-bit address):
- addr 0: control. Bit 0 run, bit 1 capture arm, bit 2 split, bit 3 full-rate select, bit 4 external select, bit 5 interrupt enable.
- addr 1: flags. Bit 0 high flag, bit 1 low flag.
- addr 2/3: count low/high byte.
- addr 4/5: reload low/high byte.

## Requirements
- R1: After reset every register reads 0 at addresses 0 to 5, and `irq` is low.
- R2: The count changes only on an enable pulse while control bit 0 (run) is 1. With run at 0, the count holds its value.
- R3: Control bit 4 at 1 selects one pulse per 8 synchronized rising edges of `ext_clk`, whatever bit 3 holds. Otherwise bit 3 at 1 gives a pulse every system cycle, and bit 3 at 0 gives one pulse per 12 cycles. Both dividers restart from zero while run is 0.
- R4: Capture mode is active only when control bit 1 is 1 and bit 2 is 0.
- R5: In capture mode, a rising edge of `cmp_in` copies the full 16-bit count into the reload register. The copy happens on the third clock edge after `cmp_in` is first sampled high (two synchronizer stages, then edge detect). A falling edge captures nothing.
- R6: A capture sets the high flag (flags bit 0). `irq` is high exactly when control bit 5 is 1 and at least one flag is set.
- R7: When a capture and a count increment fall on the same edge, the value captured is the count before the increment.
- R8: In capture mode the counter wraps from 0xFFFF to 0x0000 without loading the reload value, and the wrap sets the high flag.
- R9: In 16-bit mode without capture, an increment at 0xFFFF loads the reload value and sets the high flag.
- R10: In split mode, each byte counts on the same pulse. A byte at 0xFF reloads from its own reload byte. The low byte's overflow sets flags bit 1, and the high byte's overflow sets flags bit 0.
- R11: Writing a flags bit as 0 clears that flag, and writing it as 1 leaves the flag unchanged. A set on the same edge as a clear wins.
- R12: With capture mode inactive, comparator edges change neither the reload register nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address for read and write |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| cmp_in | input | 1 | Asynchronous comparator output |
| ext_clk | input | 1 | Asynchronous slow external clock |
| irq | output | 1 | Interrupt request level |

## Verification
The bench lands a comparator capture on the same edge as an increment. A design that captures after the increment returns a value one too high. On that same edge it also writes a flag clear, so a design where the clear wins would lose the capture interrupt.

The bench drives the counter through 0xFFFF in each mode. A design that reloads in capture mode, or shares one reload value across split halves, ends on a visibly wrong count.

It also toggles the comparator with capture disarmed, or with split mode set. A falling edge is applied as well. A design that captures on any of these would overwrite the reload register and set a flag.

// File: rtl/tmr_cap_pkg.sv
package tmr_cap_pkg;

  // Register addresses of the byte-wide access port.
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_FLAGS  = 3'd1,
    REG_CNT_LO = 3'd2,
    REG_CNT_HI = 3'd3,
    REG_RLD_LO = 3'd4,
    REG_RLD_HI = 3'd5
  } reg_addr_e;

  // Control register layout, MSB first (bit 5 .. bit 0).
  typedef struct packed {
    logic irq_en;
    logic ext_sel;
    logic fast;
    logic split;
    logic cap_en;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) sync_q[i] <= sync_q[i-1];
      sync_q[0] <= async_in;
      last_q    <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

  // R5: an edge pulse lasts exactly one cycle.
  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV_SYS = 12,
  parameter int DIV_EXT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic fast,
  input  logic ext_sel,
  input  logic ext_rise,
  output logic tick
);

  logic sys_pulse;
  logic ext_pulse;

  generate
    if (DIV_SYS > 1) begin : g_sys_div
      localparam int SW = $clog2(DIV_SYS);
      logic [SW-1:0] sys_cnt_q;
      logic          sys_last;
      assign sys_last = (sys_cnt_q == SW'(DIV_SYS - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run) sys_cnt_q <= '0;
        else if (sys_last)  sys_cnt_q <= '0;
        else                sys_cnt_q <= sys_cnt_q + 1'b1;
      end
      assign sys_pulse = run & sys_last;
    end else begin : g_sys_pass
      assign sys_pulse = run;
    end

    if (DIV_EXT > 1) begin : g_ext_div
      localparam int EW = $clog2(DIV_EXT);
      logic [EW-1:0] ext_cnt_q;
      logic          ext_last;
      assign ext_last = (ext_cnt_q == EW'(DIV_EXT - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || !run) ext_cnt_q <= '0;
        else if (ext_rise)  ext_cnt_q <= ext_last ? '0 : ext_cnt_q + 1'b1;
      end
      assign ext_pulse = run & ext_rise & ext_last;
    end else begin : g_ext_pass
      assign ext_pulse = run & ext_rise;
    end
  endgenerate

  always_comb begin
    if (ext_sel)   tick = ext_pulse;
    else if (fast) tick = run;
    else           tick = sys_pulse;
  end

  // R2: no enable pulse while stopped.
  a_r2_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);

  // R3: the divided system rate never yields two pulses back to back.
  a_r3_div_sparse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !fast && !ext_sel && DIV_SYS > 1) |=> !tick);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               cap_en,
  input  logic               split,
  input  logic               cap_rise,
  input  logic               cnt_wr_lo,
  input  logic               cnt_wr_hi,
  input  logic               rld_wr_lo,
  input  logic               rld_wr_hi,
  input  logic [CNT_W/2-1:0] wbyte,
  input  logic               clr_hi,
  input  logic               clr_lo,
  output logic [CNT_W-1:0]   cnt,
  output logic [CNT_W-1:0]   rld,
  output logic               flag_hi,
  output logic               flag_lo
);

  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] cnt_lo_q, cnt_hi_q, rld_lo_q, rld_hi_q;
  logic              flag_hi_q, flag_lo_q;

  logic              cap_mode, cap_ev, cnt_wr_any, adv;
  logic              lo_full, hi_full;
  logic [HALF_W-1:0] next_lo, next_hi;
  logic [CNT_W-1:0]  next_full;
  logic              wrap_lo, wrap_hi;
  logic              set_hi, set_lo;

  assign cap_mode   = cap_en & ~split;
  assign cap_ev     = cap_mode & cap_rise;
  assign cnt_wr_any = cnt_wr_lo | cnt_wr_hi;
  assign adv        = tick & ~cnt_wr_any;
  assign lo_full    = &cnt_lo_q;
  assign hi_full    = &cnt_hi_q;

  // Next count for the selected layout.
  always_comb begin
    next_full = {cnt_hi_q, cnt_lo_q} + 1'b1;
    if (split) begin
      next_lo = lo_full ? rld_lo_q : cnt_lo_q + 1'b1;
      next_hi = hi_full ? rld_hi_q : cnt_hi_q + 1'b1;
      wrap_lo = lo_full;
      wrap_hi = hi_full;
    end else begin
      if (lo_full && hi_full)
        next_full = cap_mode ? '0 : {rld_hi_q, rld_lo_q};
      next_lo = next_full[HALF_W-1:0];
      next_hi = next_full[CNT_W-1:HALF_W];
      wrap_lo = 1'b0;
      wrap_hi = lo_full & hi_full;
    end
  end

  // Counter: a register write blocks the increment for that edge.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_lo_q <= '0;
      cnt_hi_q <= '0;
    end else if (cnt_wr_any) begin
      if (cnt_wr_lo) cnt_lo_q <= wbyte;
      if (cnt_wr_hi) cnt_hi_q <= wbyte;
    end else if (adv) begin
      cnt_lo_q <= next_lo;
      cnt_hi_q <= next_hi;
    end
  end

  // Reload / capture register: capture wins over a register write.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_lo_q <= '0;
      rld_hi_q <= '0;
    end else if (cap_ev) begin
      rld_lo_q <= cnt_lo_q;
      rld_hi_q <= cnt_hi_q;
    end else begin
      if (rld_wr_lo) rld_lo_q <= wbyte;
      if (rld_wr_hi) rld_hi_q <= wbyte;
    end
  end

  // Flags: set has priority over clear.
  assign set_hi = (adv & wrap_hi) | cap_ev;
  assign set_lo = adv & wrap_lo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_hi_q <= 1'b0;
      flag_lo_q <= 1'b0;
    end else begin
      if (set_hi)      flag_hi_q <= 1'b1;
      else if (clr_hi) flag_hi_q <= 1'b0;
      if (set_lo)      flag_lo_q <= 1'b1;
      else if (clr_lo) flag_lo_q <= 1'b0;
    end
  end

  assign cnt     = {cnt_hi_q, cnt_lo_q};
  assign rld     = {rld_hi_q, rld_lo_q};
  assign flag_hi = flag_hi_q;
  assign flag_lo = flag_lo_q;

  // R5: the reload register receives the count seen at the capture edge.
  a_r5_capture_copies: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (rld == $past(cnt)));

  // R7: a concurrent increment does not leak into the captured value.
  a_r7_pre_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && adv) |=> (rld != cnt));

  // R6 / R11: a capture leaves the high flag set, even against a clear.
  a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && clr_hi) |=> flag_hi);

  // R2: without an enable pulse or a write, the count is frozen.
  a_r2_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr_any) |=> $stable(cnt));

  // R8: capture mode wraps to zero.
  a_r8_cap_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cap_mode && (&cnt)) |=> (cnt == '0) && flag_hi);

  // R12 / R4: outside capture mode, only writes alter the reload register.
  a_r12_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_mode && !rld_wr_lo && !rld_wr_hi) |=> $stable(rld));

endmodule

// File: rtl/tmr_cap_top.sv
module tmr_cap_top
  import tmr_cap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DIV_SYS     = 12,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         reg_addr,
  input  logic               reg_wr,
  input  logic [CNT_W/2-1:0] reg_wdata,
  output logic [CNT_W/2-1:0] reg_rdata,
  input  logic               cmp_in,
  input  logic               ext_clk,
  output logic               irq
);

  localparam int HALF_W = CNT_W / 2;

  ctrl_t            ctrl_q;
  reg_addr_e        addr;
  logic             cmp_rise, ext_rise, tick;
  logic [CNT_W-1:0] cnt, rld;
  logic             flag_hi, flag_lo;
  logic             wr_ctrl, wr_flags;

  assign addr     = reg_addr_e'(reg_addr);
  assign wr_ctrl  = reg_wr && (addr == REG_CTRL);
  assign wr_flags = reg_wr && (addr == REG_FLAGS);

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cmp_sync (
    .clk(clk), .rst_n(rst_n), .async_in(cmp_in), .rise(cmp_rise));

  tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .rise(ext_rise));

  tmr_tick_gen #(.DIV_SYS(DIV_SYS), .DIV_EXT(DIV_EXT)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .fast(ctrl_q.fast),
    .ext_sel(ctrl_q.ext_sel), .ext_rise(ext_rise), .tick(tick));

  tmr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .cap_en    (ctrl_q.cap_en),
    .split     (ctrl_q.split),
    .cap_rise  (cmp_rise),
    .cnt_wr_lo (reg_wr && addr == REG_CNT_LO),
    .cnt_wr_hi (reg_wr && addr == REG_CNT_HI),
    .rld_wr_lo (reg_wr && addr == REG_RLD_LO),
    .rld_wr_hi (reg_wr && addr == REG_RLD_HI),
    .wbyte     (reg_wdata),
    .clr_hi    (wr_flags && !reg_wdata[0]),
    .clr_lo    (wr_flags && !reg_wdata[1]),
    .cnt       (cnt),
    .rld       (rld),
    .flag_hi   (flag_hi),
    .flag_lo   (flag_lo)
  );

  always_comb begin
    case (addr)
      REG_CTRL:   reg_rdata = HALF_W'(ctrl_q);
      REG_FLAGS:  reg_rdata = HALF_W'({flag_lo, flag_hi});
      REG_CNT_LO: reg_rdata = cnt[HALF_W-1:0];
      REG_CNT_HI: reg_rdata = cnt[CNT_W-1:HALF_W];
      REG_RLD_LO: reg_rdata = rld[HALF_W-1:0];
      REG_RLD_HI: reg_rdata = rld[CNT_W-1:HALF_W];
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = ctrl_q.irq_en & (flag_hi | flag_lo);

  // R6: with interrupts disabled the request stays low.
  a_r6_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.irq_en |-> !irq);

endmodule

// File: tb/sim_tmr_cap_top.sv
`timescale 1ns/1ps
module sim_tmr_cap_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmp_in = 1'b0;
  logic       ext_clk = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  tmr_cap_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
    .ext_clk(ext_clk), .irq(irq));

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] cnt;
    logic [15:0] rld;
    logic [15:0] ncyc;
    logic [15:0] ecnt;
    logic [15:0] erld;
    logic [7:0]  eflg;
  } vec_t;

  // ctrl bits: 0 run, 1 capture arm, 2 split, 3 full rate, 4 external, 5 irq enable
  localparam vec_t VEC [0:7] = '{
    '{8'h09, 16'h1234, 16'h0000, 16'd10, 16'h123E, 16'h0000, 8'h00}, // R2 full rate
    '{8'h08, 16'h1234, 16'h0000, 16'd10, 16'h1234, 16'h0000, 8'h00}, // R2 stopped
    '{8'h01, 16'h0100, 16'h0000, 16'd30, 16'h0102, 16'h0000, 8'h00}, // R3 div 12
    '{8'h09, 16'hFFFE, 16'h8000, 16'd5,  16'h8003, 16'h8000, 8'h01}, // R9 reload
    '{8'h0B, 16'hFFFE, 16'h8000, 16'd5,  16'h0003, 16'h8000, 8'h01}, // R8 cap wrap
    '{8'h0D, 16'h12FE, 16'h3456, 16'd4,  16'h1658, 16'h3456, 8'h02}, // R10 low wrap
    '{8'h0D, 16'hFF10, 16'h2000, 16'd3,  16'h2213, 16'h2000, 8'h01}, // R10 high wrap
    '{8'h01, 16'hFFFF, 16'h0042, 16'd24, 16'h0043, 16'h0042, 8'h01}  // R9 via div 12
  };

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge after one write edge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd16(input logic [2:0] a_lo, output logic [15:0] d);
    logic [7:0] lo, hi;
    rd(a_lo, lo);
    rd(a_lo + 3'd1, hi);
    d = {hi, lo};
  endtask

  task automatic load(input logic [15:0] c, input logic [15:0] r);
    wr(3'd2, c[7:0]); wr(3'd3, c[15:8]);
    wr(3'd4, r[7:0]); wr(3'd5, r[15:8]);
    wr(3'd1, 8'h00);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    done = 1'b1;
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    vec_t        v;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd(a[2:0], b);
      chk("R1", "reset read", {8'h00, b}, 16'h0000);
    end
    chk("R1", "irq after reset", {15'd0, irq}, 16'h0000);

    // Table walk
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      load(v.cnt, v.rld);
      wr(3'd0, v.ctrl);
      repeat (int'(v.ncyc) - 1) @(posedge clk);
      @(negedge clk);
      wr(3'd0, v.ctrl & 8'hFE);
      rd16(3'd2, w); chk("R2/R3/R8/R9/R10", "vector count", w, v.ecnt);
      rd16(3'd4, w); chk("R8/R9/R10", "vector reload", w, v.erld);
      rd(3'd1, b);   chk("R8/R9/R10", "vector flags", {8'h00, b}, {8'h00, v.eflg});
    end

    // R5 R7 R11: capture on edge E3 concurrent with increment and flag clear
    load(16'h0500, 16'h0000);
    wr(3'd0, 8'h2B);            // E0: run, capture, full rate, irq enable
    cmp_in = 1'b1;
    @(posedge clk);             // E1
    @(posedge clk);             // E2
    @(negedge clk);
    wr(3'd1, 8'h00);            // E3: capture edge plus clear request
    wr(3'd0, 8'h2A);            // E4: stop
    rd16(3'd4, w); chk("R7", "captured pre-increment count", w, 16'h0502);
    rd(3'd1, b);   chk("R11", "set beats clear", {8'h00, b}, 16'h0001);
    chk("R6", "irq with flag", {15'd0, irq}, 16'h0001);
    rd16(3'd2, w); chk("R2", "count after stop", w, 16'h0504);
    wr(3'd1, 8'h00);
    chk("R6", "irq after clear", {15'd0, irq}, 16'h0000);

    // R5: falling edge captures nothing
    cmp_in = 1'b0;
    repeat (6) @(negedge clk);
    rd16(3'd4, w); chk("R5", "reload after falling edge", w, 16'h0502);
    rd(3'd1, b);   chk("R5", "flags after falling edge", {8'h00, b}, 16'h0000);

    // R12: capture disarmed, running
    wr(3'd0, 8'h09);
    cmp_in = 1'b1;
    repeat (6) @(negedge clk);
    wr(3'd0, 8'h08);
    rd16(3'd4, w); chk("R12", "reload with capture off", w, 16'h0502);
    rd(3'd1, b);   chk("R12", "flags with capture off", {8'h00, b}, 16'h0000);
    cmp_in = 1'b0;
    repeat (6) @(negedge clk);

    // R4: capture armed but split selected
    wr(3'd0, 8'h0E);
    cmp_in = 1'b1;
    repeat (6) @(negedge clk);
    rd16(3'd4, w); chk("R4", "reload in split", w, 16'h0502);
    rd(3'd1, b);   chk("R4", "flags in split", {8'h00, b}, 16'h0000);
    cmp_in = 1'b0;
    repeat (6) @(negedge clk);

    // R11: selective clearing
    load(16'hFFFF, 16'h0000);
    wr(3'd0, 8'h0D);
    wr(3'd0, 8'h0C);
    rd(3'd1, b);   chk("R10", "both halves wrapped", {8'h00, b}, 16'h0003);
    wr(3'd1, 8'h02);
    rd(3'd1, b);   chk("R11", "clear high keep low", {8'h00, b}, 16'h0002);
    wr(3'd1, 8'h01);
    rd(3'd1, b);   chk("R11", "clear low", {8'h00, b}, 16'h0000);

    // R3: external clock divided by 8
    load(16'h0010, 16'h0000);
    wr(3'd0, 8'h19);            // external select overrides full rate
    for (int k = 0; k < 16; k++) begin
      ext_clk = 1'b1; repeat (2) @(negedge clk);
      ext_clk = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    wr(3'd0, 8'h18);
    rd16(3'd2, w); chk("R3", "external divide by 8", w, 16'h0012);

    finish_run();
  end

endmodule